// File: doc/BRIEF.md
# Oversampling Serial Character Receiver with Break and Idle Timeout

This block turns an asynchronous serial input into 8-bit characters. Bit timing comes from a single-cycle enable, `tick`, that pulses at sixteen times the baud rate. The line rests high. A sampled low level starts a frame. The start bit is confirmed half a bit later, and each following bit is read at its centre, one bit time after the previous centre. Data arrives least significant bit first. An optional parity bit follows, then a stop bit. Each character is handed out on a one-cycle strobe together with its framing and parity flags.

Beside the frame engine, a line monitor watches the synchronised input. It reports a break once the line has stayed low for a programmed number of whole character times. It also raises an idle timeout once the line has stayed high for a programmed number of bit times after the last character or the last low sample. The frame engine is a state machine with the states S_IDLE, S_START, S_DATA, S_PAR and S_STOP. All transitions are taken only on tick cycles:

- S_IDLE to S_START when a low sample is seen.
- S_START to S_IDLE (glitch) or to S_DATA at the start-bit centre.
- S_DATA to S_PAR (parity on) or to S_STOP (parity off) after the last data bit.
- S_PAR to S_STOP after the parity bit.
- S_STOP to S_IDLE at the stop-bit centre, where the character is delivered.

Top module: `ser_rx`

## Requirements
- R1: The state machine and the line counters advance only on cycles where `tick` is 1. Every output strobe appears in the clock cycle that follows a tick cycle. With `tick` held at 0, no output ever pulses.
- R2: In S_IDLE, a low sample on a tick starts a frame. The start bit is sampled again 8 ticks later. If that sample is high, the frame is dropped as a glitch with no strobe, and the machine returns to S_IDLE.
- R3: Data bits are sampled 16 ticks apart, the first one 16 ticks after the start-bit centre. The first bit received becomes bit 0 of `char_data`.
- R4: The stop bit is sampled at its centre. If it reads 0, `frm_err` is 1 in the strobe cycle.
- R5: With `par_en`=1, a parity bit follows the 8 data bits. `par_err` is 1 when the XOR of the 8 data bits and the parity bit differs from `par_odd` (0 selects even parity, 1 selects odd parity). With `par_en`=0, `par_err` stays 0.
- R6: Each character gives exactly one single-cycle `char_vld` pulse. `frm_err` and `par_err` are 1 only in that cycle. A start bit that directly follows a stop bit is received as a new character.
- R7: `brk_pulse` pulses once when the line has been low for `brk_chars` × (10 + `par_en`) × 16 consecutive ticks. A value of 0 for `brk_chars` disables break detection. The detector rearms only after the line is sampled high.
- R8: `to_pulse` pulses once when the line has been high for `to_bits` × 16 ticks since the later of the last `char_vld` and the last low sample. It pulses only when `to_en`=1 and `to_bits` is not 0. It fires once per idle period.
- R9: After reset, all output strobes and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable at 16x the baud rate |
| rxd | input | 1 | Serial input, idle high |
| par_en | input | 1 | Expect a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| brk_chars | input | BRK_W (4) | Break length in character times; 0 disables |
| to_en | input | 1 | Idle timeout enable |
| to_bits | input | TO_W (16) | Idle timeout length in bit times |
| char_vld | output | 1 | Character strobe |
| char_data | output | DATA_W (8) | Received character, valid with `char_vld` |
| frm_err | output | 1 | Stop bit read low |
| par_err | output | 1 | Parity mismatch |
| brk_pulse | output | 1 | Break detected |
| to_pulse | output | 1 | Idle timeout |

## Verification
The hardest situations to reach are the break and the timeout thresholds, because both span hundreds of ticks. The break case is made harder because a long low level also produces framing-error characters as a side effect. The bench holds the line low for just under and just over two character times. It counts break pulses separately from character strobes, and repeats the longer hold to show that the detector rearms. For the timeout, the bench first delivers a character to restart the count. It then checks that no pulse has appeared partway through the window, that exactly one pulse has appeared after the window, and that none appears with the enable cleared.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP
    } rx_state_e;
endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ser_rx_frame.sv
module ser_rx_frame
    import ser_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              char_vld,
    output logic [DATA_W-1:0] char_data,
    output logic              frm_err,
    output logic              par_err
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

    rx_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] bit_idx;
    logic [DATA_W-1:0] shreg;
    logic             par_bit;
    logic             mid;

    assign mid = tick && ((state == S_START) ? (cnt == HALF_LAST) : (cnt == FULL_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (tick && !rx) state_nx = S_START;
            S_START: if (mid) state_nx = rx ? S_IDLE : S_DATA;
            S_DATA:  if (mid && bit_idx == IDX_LAST) state_nx = par_en ? S_PAR : S_STOP;
            S_PAR:   if (mid) state_nx = S_STOP;
            S_STOP:  if (mid) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            char_vld <= 1'b0;
            frm_err  <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            char_vld <= 1'b0;
            frm_err  <= 1'b0;
            par_err  <= 1'b0;
            if (tick) begin
                if (state == S_IDLE || mid) cnt <= '0;
                else                        cnt <= cnt + 1'b1;
            end
            if (mid) begin
                unique case (state)
                    S_START: bit_idx <= '0;
                    S_DATA: begin
                        shreg   <= {rx, shreg[DATA_W-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                    S_PAR:   par_bit <= rx;
                    S_STOP: begin
                        char_vld <= 1'b1;
                        frm_err  <= !rx;
                        par_err  <= par_en && ((^shreg ^ par_bit) != par_odd);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign char_data = shreg;
endmodule

// File: rtl/ser_rx_linemon.sv
module ser_rx_linemon #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int BRK_W  = 4,
    parameter int TO_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rx,
    input  logic             par_en,
    input  logic             char_vld,
    input  logic [BRK_W-1:0] brk_chars,
    input  logic             to_en,
    input  logic [TO_W-1:0]  to_bits,
    output logic             brk_pulse,
    output logic             to_pulse
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W = $clog2(OSR);
    localparam int LB_W  = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] TK_LAST = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] lo_tk, id_tk;
    logic [LB_W-1:0]  lo_bit, bit_last;
    logic [BRK_W-1:0] lo_chr, lo_chr_nx;
    logic [TO_W-1:0]  id_bits, id_bits_nx;
    logic             brk_done, to_done;

    assign bit_last   = par_en ? LB_W'(FRAME_BITS) : LB_W'(FRAME_BITS - 1);
    assign lo_chr_nx  = lo_chr + 1'b1;
    assign id_bits_nx = id_bits + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_tk <= '0; lo_bit <= '0; lo_chr <= '0;
            brk_done <= 1'b0; brk_pulse <= 1'b0;
        end else begin
            brk_pulse <= 1'b0;
            if (rx) begin
                lo_tk <= '0; lo_bit <= '0; lo_chr <= '0;
                brk_done <= 1'b0;
            end else if (tick && !brk_done) begin
                if (lo_tk == TK_LAST) begin
                    lo_tk <= '0;
                    if (lo_bit == bit_last) begin
                        lo_bit <= '0;
                        lo_chr <= lo_chr_nx;
                        if (brk_chars != '0 && lo_chr_nx == brk_chars) begin
                            brk_done  <= 1'b1;
                            brk_pulse <= 1'b1;
                        end
                    end else begin
                        lo_bit <= lo_bit + 1'b1;
                    end
                end else begin
                    lo_tk <= lo_tk + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_tk <= '0; id_bits <= '0;
            to_done <= 1'b0; to_pulse <= 1'b0;
        end else begin
            to_pulse <= 1'b0;
            if (!rx || char_vld) begin
                id_tk <= '0; id_bits <= '0;
                to_done <= 1'b0;
            end else if (tick && !to_done) begin
                if (id_tk == TK_LAST) begin
                    id_tk   <= '0;
                    id_bits <= id_bits_nx;
                    if (to_bits != '0 && id_bits_nx == to_bits) begin
                        to_done  <= 1'b1;
                        to_pulse <= to_en;
                    end
                end else begin
                    id_tk <= id_tk + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ser_rx.sv
module ser_rx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int BRK_W  = 4,
    parameter int TO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [BRK_W-1:0]  brk_chars,
    input  logic              to_en,
    input  logic [TO_W-1:0]   to_bits,
    output logic              char_vld,
    output logic [DATA_W-1:0] char_data,
    output logic              frm_err,
    output logic              par_err,
    output logic              brk_pulse,
    output logic              to_pulse
);
    logic rx_s;

    ser_rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
    );

    ser_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
        .par_en(par_en), .par_odd(par_odd),
        .char_vld(char_vld), .char_data(char_data),
        .frm_err(frm_err), .par_err(par_err)
    );

    ser_rx_linemon #(.DATA_W(DATA_W), .OSR(OSR), .BRK_W(BRK_W), .TO_W(TO_W)) u_mon (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s),
        .par_en(par_en), .char_vld(char_vld),
        .brk_chars(brk_chars), .to_en(to_en), .to_bits(to_bits),
        .brk_pulse(brk_pulse), .to_pulse(to_pulse)
    );
endmodule

// File: rtl/ser_rx_chk.sv
module ser_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic par_en,
    input logic to_en,
    input logic char_vld,
    input logic frm_err,
    input logic par_err,
    input logic brk_pulse,
    input logic to_pulse
);
    AST_VLD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld |-> $past(tick)); // R1
    AST_BRK_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |-> $past(tick)); // R1
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld |=> !char_vld); // R6
    AST_FLAGS_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_err || par_err) |-> char_vld); // R6
    AST_NO_PAR_ERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && !par_en) |-> !par_err); // R5
    AST_BRK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse |=> !brk_pulse); // R7
    AST_TO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        to_pulse |-> to_en); // R8
    AST_TO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        to_pulse |=> !to_pulse); // R8
endmodule

bind ser_rx ser_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(par_en), .to_en(to_en),
    .char_vld(char_vld), .frm_err(frm_err), .par_err(par_err),
    .brk_pulse(brk_pulse), .to_pulse(to_pulse)
);

// File: tb/tb_ser_rx.sv
module tb_ser_rx;
    localparam int BIT_CLK = 64; // 4 clocks per tick, 16 ticks per bit

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        rxd = 1'b1;
    logic        par_en = 1'b0, par_odd = 1'b0, to_en = 1'b0;
    logic [3:0]  brk_chars = 4'd0;
    logic [15:0] to_bits = 16'd0;
    logic        char_vld, frm_err, par_err, brk_pulse, to_pulse;
    logic [7:0]  char_data;

    int checks = 0, failures = 0, cyc = 0;
    int n_vld = 0, n_brk = 0, n_to = 0, n_any = 0;
    logic [7:0] first_data, last_data;
    logic first_frm, first_par;
    bit tick_en = 1'b1, finished = 1'b0;
    int div = 0;

    ser_rx dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(par_en),
        .par_odd(par_odd), .brk_chars(brk_chars), .to_en(to_en), .to_bits(to_bits),
        .char_vld(char_vld), .char_data(char_data), .frm_err(frm_err),
        .par_err(par_err), .brk_pulse(brk_pulse), .to_pulse(to_pulse)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk); #1;
            tick = tick_en && (div == 3);
            div = (div + 1) % 4;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (char_vld) begin
                if (n_vld == 0) begin
                    first_data = char_data; first_frm = frm_err; first_par = par_err;
                end
                last_data = char_data;
                n_vld++;
            end
            if (brk_pulse) n_brk++;
            if (to_pulse) n_to++;
            if (char_vld || brk_pulse || to_pulse || frm_err || par_err) n_any++;
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        n_vld = 0; n_brk = 0; n_to = 0; n_any = 0;
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk); rxd = b;
        wait_clk(BIT_CLK - 1);
    endtask

    task automatic send(input logic [7:0] d, input bit with_par, input logic pbit, input logic stop);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        if (with_par) drive_bit(pbit);
        drive_bit(stop);
        @(negedge clk); rxd = 1'b1;
    endtask

    task automatic settle();
        wait_clk(12 * BIT_CLK);
        clear_mon();
    endtask

    task automatic t_reset();
        chk(!char_vld && !frm_err && !par_err && !brk_pulse && !to_pulse, "R9 reset outputs",
            {char_vld, frm_err, par_err, brk_pulse, to_pulse}, 0);
    endtask

    task automatic t_plain();
        clear_mon();
        send(8'hA5, 0, 0, 1); wait_clk(2 * BIT_CLK);
        chk(n_vld == 1, "R6 one strobe per char", n_vld, 1);
        chk(first_data == 8'hA5, "R3 data lsb first", first_data, 8'hA5);
        chk(!first_frm, "R4 good stop no frm_err", first_frm, 0);
        chk(!first_par, "R5 parity off no par_err", first_par, 0);
        settle();
        send(8'h01, 0, 0, 1); wait_clk(2 * BIT_CLK);
        chk(n_vld == 1 && first_data == 8'h01, "R3 data 0x01", first_data, 8'h01);
        settle();
    endtask

    task automatic t_back_to_back();
        clear_mon();
        send(8'h3C, 0, 0, 1); send(8'hC3, 0, 0, 1); wait_clk(2 * BIT_CLK);
        chk(n_vld == 2, "R6 back-to-back count", n_vld, 2);
        chk(first_data == 8'h3C && last_data == 8'hC3, "R6 back-to-back data", last_data, 8'hC3);
        settle();
    endtask

    task automatic t_framing();
        clear_mon();
        send(8'h5A, 0, 0, 0); wait_clk(BIT_CLK / 4);
        chk(n_vld >= 1 && first_frm, "R4 low stop gives frm_err", first_frm, 1);
        chk(first_data == 8'h5A, "R4 data kept with frm_err", first_data, 8'h5A);
        settle();
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_odd = 1'b0; clear_mon();
        send(8'h3C, 1, 1'b0, 1); wait_clk(2 * BIT_CLK);
        chk(n_vld == 1 && !first_par, "R5 even parity ok", first_par, 0);
        chk(first_data == 8'h3C, "R5 data with parity", first_data, 8'h3C);
        settle();
        send(8'h3C, 1, 1'b1, 1); wait_clk(2 * BIT_CLK);
        chk(n_vld == 1 && first_par, "R5 even parity mismatch", first_par, 1);
        settle();
        par_odd = 1'b1;
        send(8'h07, 1, 1'b0, 1); wait_clk(2 * BIT_CLK);
        chk(n_vld == 1 && !first_par, "R5 odd parity ok", first_par, 0);
        settle();
        send(8'h07, 1, 1'b1, 1); wait_clk(2 * BIT_CLK);
        chk(n_vld == 1 && first_par, "R5 odd parity mismatch", first_par, 1);
        settle();
        par_en = 1'b0; par_odd = 1'b0;
    endtask

    task automatic t_glitch();
        clear_mon();
        @(negedge clk); rxd = 1'b0; wait_clk(12); rxd = 1'b1;
        wait_clk(12 * BIT_CLK);
        chk(n_vld == 0, "R2 short low pulse rejected", n_vld, 0);
        send(8'h96, 0, 0, 1); wait_clk(2 * BIT_CLK);
        chk(n_vld == 1 && first_data == 8'h96, "R2 receive after glitch", first_data, 8'h96);
        settle();
    endtask

    task automatic t_no_tick();
        tick_en = 1'b0; brk_chars = 4'd1; to_en = 1'b1; to_bits = 16'd1;
        clear_mon();
        @(negedge clk); rxd = 1'b0; wait_clk(1200); rxd = 1'b1; wait_clk(1200);
        chk(n_any == 0, "R1 no strobe without tick", n_any, 0);
        to_en = 1'b0; brk_chars = 4'd0; to_bits = 16'd0; tick_en = 1'b1;
        settle();
    endtask

    task automatic t_break();
        brk_chars = 4'd2; clear_mon();
        @(negedge clk); rxd = 1'b0; wait_clk(15 * BIT_CLK); rxd = 1'b1;
        wait_clk(12 * BIT_CLK);
        chk(n_brk == 0, "R7 low 1.5 chars no break", n_brk, 0);
        clear_mon();
        @(negedge clk); rxd = 1'b0; wait_clk(22 * BIT_CLK);
        chk(n_brk == 1, "R7 low 2+ chars break once", n_brk, 1);
        wait_clk(20 * BIT_CLK);
        chk(n_brk == 1, "R7 no repeat while low", n_brk, 1);
        rxd = 1'b1; settle();
        @(negedge clk); rxd = 1'b0; wait_clk(22 * BIT_CLK); rxd = 1'b1;
        wait_clk(2 * BIT_CLK);
        chk(n_brk == 1, "R7 rearm after high", n_brk, 1);
        settle();
        par_en = 1'b1; clear_mon();
        @(negedge clk); rxd = 1'b0; wait_clk(21 * BIT_CLK);
        chk(n_brk == 0, "R7 parity lengthens char time", n_brk, 0);
        wait_clk(2 * BIT_CLK); rxd = 1'b1; wait_clk(2 * BIT_CLK);
        chk(n_brk == 1, "R7 break with parity", n_brk, 1);
        par_en = 1'b0; settle();
        brk_chars = 4'd0;
        @(negedge clk); rxd = 1'b0; wait_clk(30 * BIT_CLK); rxd = 1'b1;
        wait_clk(2 * BIT_CLK);
        chk(n_brk == 0, "R7 zero disables break", n_brk, 0);
        settle();
    endtask

    task automatic t_timeout();
        to_bits = 16'd20; to_en = 1'b1; clear_mon();
        send(8'h42, 0, 0, 1);
        wait_clk(14 * BIT_CLK);
        chk(n_to == 0, "R8 no timeout before window", n_to, 0);
        wait_clk(16 * BIT_CLK);
        chk(n_to == 1, "R8 timeout after window", n_to, 1);
        wait_clk(30 * BIT_CLK);
        chk(n_to == 1, "R8 single timeout per idle", n_to, 1);
        clear_mon();
        send(8'h42, 0, 0, 1); wait_clk(10 * BIT_CLK);
        send(8'h43, 0, 0, 1); wait_clk(14 * BIT_CLK);
        chk(n_to == 0, "R8 restart on new char", n_to, 0);
        wait_clk(10 * BIT_CLK);
        chk(n_to == 1, "R8 timeout after restart", n_to, 1);
        to_en = 1'b0; clear_mon();
        send(8'h42, 0, 0, 1); wait_clk(30 * BIT_CLK);
        chk(n_to == 0, "R8 disabled no timeout", n_to, 0);
        to_bits = 16'd0;
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(BIT_CLK);
        t_plain();
        t_back_to_back();
        t_framing();
        t_parity();
        t_glitch();
        t_no_tick();
        t_break();
        t_timeout();
        summary();
    end
endmodule